// File: doc/BRIEF.md
# DSI Video Frame Sequencer

This block produces the timing skeleton of a display serial link running in video mode. Two counters drive it. A cycle counter steps through each line in byte-clock cycles. A line counter steps through the vertical regions of a frame. From these it decodes the current vertical and horizontal region and pulses a one-cycle strobe whenever a packet should go out. The packet kinds are a line-start sync, a sync-end in pulse mode, a pixel chunk and a null filler.

A pixel data path would use the chunk strobes to emit payload. A lane controller would use `lp_ok` to decide when the lanes may leave high-speed mode.

Every input except `run` is a static configuration word, loaded while `run` is low. The strobes are plain one-cycle pulses. The downstream logic must accept each strobe in the cycle it is raised, so no back-pressure path exists.

Top module: `dsi_video_sequencer`

## Requirements
- R1: While `rst_n` is low, or in the cycle after an edge that samples `run` low, every strobe and `lp_ok` are 0, and `vreg` and `hreg` are both 0.
- R2: Suppose `run` is first sampled high at edge E and `cfg_sig_delay` is D. The first line then begins after edge E+D, so `sync_start` is high in the cycle after edge E+D.
- R3: Each line lasts `cfg_line_time` cycles. `sync_start` is high in exactly the first cycle of every line.
- R4: Within a line, `hreg` follows a fixed order, encoded 0 sync, 1 back porch, 2 active, 3 front porch. It reads 0 for the sync-active time, then 1 for the back-porch time. On active lines it then reads 2 while the chunk schedule runs. It reads 3 for the rest of the line. Non-active lines go straight from 1 to 3.
- R5: `vreg` follows a fixed order, encoded 0 sync, 1 back porch, 2 active, 3 front porch. It holds each region for its programmed line count: sync lines in `cfg_vblk[29:20]`, back porch in `[19:10]`, front porch in `[9:0]` and active lines in `cfg_vact`. A region with a count of zero is skipped, and after the front porch the order wraps to the sync region. `vreg` changes only at a line start.
- R6: `cfg_mode` is 0 for non-burst with sync pulses, 1 for non-burst with sync events, and 2 or 3 for burst. In mode 0, `sync_end` is high in the cycle where the line counter equals the sync-active time. This requires a sync-active time of at least 1. In every other mode `sync_end` stays 0.
- R7: In non-burst modes, an active line starts its schedule at the end of the back porch. The schedule is a run of chunks. Each chunk is `cfg_pkt[15:0]` cycles of pixels followed by `cfg_null_size` cycles of null. The number of chunks is `cfg_pkt[31:16]`, and a count of 0 is treated as 1. `chunk_stb` marks the first pixel cycle of each chunk and `null_stb` the first null cycle.
- R8: A null size of 0 removes every null segment and every `null_stb`, and the chunks run back to back.
- R9: In burst mode an active line carries exactly one chunk and no null packet, whatever the chunk count and null size are.
- R10: `chunk_stb` and `null_stb` occur only on lines where `vreg` is 2.
- R11: `cfg_lp_en` grants low power per region. The bit mapping is: bit 0 vertical sync lines, bit 1 vertical back-porch lines, bit 2 the sync-active part of active lines, bit 3 vertical front-porch lines, bit 4 horizontal back porch, bit 5 horizontal front porch. The active part of an active line never grants low power.
- R12: `lp_ok` is 0 in the first cycle of a line. In mode 0 it is also 0 in every cycle up to and including the `sync_end` cycle, because a packet is still pending there.
- R13: `cfg_hblk` carries the sync-active time in bits 31:16 and the back-porch time in bits 15:0, both in byte-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| run | input | 1 | Sequencing enable; low returns to idle |
| cfg_mode | input | 2 | 0 sync pulses, 1 sync events, 2/3 burst |
| cfg_hblk | input | 32 | Sync-active time [31:16], back-porch time [15:0] |
| cfg_line_time | input | 16 | Total line length in cycles |
| cfg_vblk | input | 30 | Sync lines [29:20], back-porch lines [19:10], front-porch lines [9:0] |
| cfg_vact | input | 12 | Active line count |
| cfg_pkt | input | 32 | Chunk count [31:16], chunk pixel length [15:0] |
| cfg_null_size | input | 10 | Null segment length, 0 disables |
| cfg_lp_en | input | 6 | Per-region low-power grants (see R11) |
| cfg_sig_delay | input | 24 | Start hold-off in cycles |
| vreg | output | 2 | Current vertical region |
| hreg | output | 2 | Current horizontal region |
| sync_start | output | 1 | Line-start sync strobe |
| sync_end | output | 1 | Sync-end strobe (pulse mode) |
| chunk_stb | output | 1 | Pixel chunk start strobe |
| null_stb | output | 1 | Null packet start strobe |
| lp_ok | output | 1 | Lanes may enter low power this cycle |

## Verification
A wrong cycle counter moves `sync_start` off its period within a single line. A wrong line counter or region selector shows up as a wrong `vreg` at the next line start. A chunk scheduler stuck in the wrong segment misplaces `chunk_stb` or `null_stb` within the same active line. The `hreg` change from 2 to 3 then comes early or late, and the low-power cycle count of that line changes with it. The low-power gate is checked against its pending-packet rule, so a grant that overlaps any strobe is caught in that very cycle.

// File: rtl/dsi_vseq_pkg.sv
package dsi_vseq_pkg;

  typedef enum logic [1:0] {
    V_SYNC  = 2'd0,
    V_BACK  = 2'd1,
    V_ACT   = 2'd2,
    V_FRONT = 2'd3
  } vreg_e;

  typedef enum logic [1:0] {
    H_SYNC  = 2'd0,
    H_BACK  = 2'd1,
    H_ACT   = 2'd2,
    H_FRONT = 2'd3
  } hreg_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_GO   = 2'd2
  } phase_e;

  localparam logic [1:0] MODE_PULSE = 2'd0;

  // low-power grant bit positions
  localparam int LP_VSYNC = 0;
  localparam int LP_VBACK = 1;
  localparam int LP_VACT  = 2;
  localparam int LP_VFRNT = 3;
  localparam int LP_HBACK = 4;
  localparam int LP_HFRNT = 5;
  localparam int LP_BITS  = 6;

endpackage

// File: rtl/dsi_vseq_timer.sv
module dsi_vseq_timer
  import dsi_vseq_pkg::*;
#(
  parameter int HT_W  = 16,
  parameter int VL_W  = 10,
  parameter int VA_W  = 12,
  parameter int DLY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [HT_W-1:0]  line_time,
  input  logic [VL_W-1:0]  vsa_lines,
  input  logic [VL_W-1:0]  vbp_lines,
  input  logic [VL_W-1:0]  vfp_lines,
  input  logic [VA_W-1:0]  vact_lines,
  input  logic [DLY_W-1:0] sig_delay,
  output logic             running,
  output logic [HT_W-1:0]  hcnt,
  output vreg_e            vreg,
  output logic             line_last
);

  phase_e           phase;
  logic [DLY_W-1:0] dcnt;
  logic [VA_W-1:0]  vcnt;
  logic [VA_W-1:0]  region_len [4];
  logic [HT_W-1:0]  lt_m1;
  vreg_e            first_reg;
  vreg_e            nxt_reg;
  logic             region_last;

  always_comb begin
    region_len[0] = VA_W'(vsa_lines);
    region_len[1] = VA_W'(vbp_lines);
    region_len[2] = vact_lines;
    region_len[3] = VA_W'(vfp_lines);
  end

  // lowest-numbered region with a nonzero count starts the frame
  always_comb begin
    first_reg = V_SYNC;
    for (int k = 3; k >= 0; k--) begin
      if (region_len[k] != '0) first_reg = vreg_e'(k[1:0]);
    end
  end

  // next region in frame order, skipping empty ones
  always_comb begin
    nxt_reg = vreg_e'(2'(int'(vreg) + 1));
    for (int k = 4; k >= 1; k--) begin
      if (region_len[2'(int'(vreg) + k)] != '0) nxt_reg = vreg_e'(2'(int'(vreg) + k));
    end
  end

  assign lt_m1       = (line_time == '0) ? '0 : line_time - 1'b1;
  assign running     = (phase == PH_GO);
  assign line_last   = running && (hcnt >= lt_m1);
  assign region_last = (region_len[vreg] == '0) || (vcnt >= region_len[vreg] - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= PH_IDLE;
      dcnt  <= '0;
      hcnt  <= '0;
      vcnt  <= '0;
      vreg  <= V_SYNC;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (sig_delay == '0) begin
            phase <= PH_GO;
            hcnt  <= '0;
            vcnt  <= '0;
            vreg  <= first_reg;
          end else begin
            phase <= PH_WAIT;
            dcnt  <= DLY_W'(1);
          end
        end
        PH_WAIT: begin
          if (dcnt >= sig_delay) begin
            phase <= PH_GO;
            hcnt  <= '0;
            vcnt  <= '0;
            vreg  <= first_reg;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: begin
          if (line_last) begin
            hcnt <= '0;
            if (region_last) begin
              vcnt <= '0;
              vreg <= nxt_reg;
            end else begin
              vcnt <= vcnt + 1'b1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
      endcase
    end
  end

  a_r3_hcnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && hcnt != '0) |-> (hcnt == $past(hcnt) + 1'b1));

  a_r5_vreg_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && vreg != $past(vreg)) |-> (hcnt == '0));

endmodule

// File: rtl/dsi_vseq_chunker.sv
module dsi_vseq_chunker
  import dsi_vseq_pkg::*;
#(
  parameter int HT_W  = 16,
  parameter int PS_W  = 16,
  parameter int CNT_W = 16,
  parameter int NS_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             active_line,
  input  logic             line_last,
  input  logic [HT_W-1:0]  hcnt,
  input  logic [HT_W:0]    hact_start,
  input  logic [PS_W-1:0]  pkt_size,
  input  logic [CNT_W-1:0] chunks,
  input  logic [NS_W-1:0]  null_size,
  input  logic             burst,
  output logic             in_hact,
  output logic             chunk_stb,
  output logic             null_stb
);

  localparam int POS_W = (PS_W > NS_W) ? PS_W : NS_W;

  logic [POS_W-1:0] seg_pos;
  logic             seg_null;
  logic [CNT_W-1:0] chunk_idx;
  logic             done;
  logic [POS_W-1:0] eff_pkt;
  logic [POS_W-1:0] eff_null;
  logic [CNT_W-1:0] eff_chunks;
  logic             last_chunk;

  // burst forces one chunk with no filler; zero sizes are clamped
  assign eff_pkt    = (pkt_size == '0) ? POS_W'(1) : POS_W'(pkt_size);
  assign eff_null   = burst ? '0 : POS_W'(null_size);
  assign eff_chunks = (burst || chunks == '0) ? CNT_W'(1) : chunks;
  assign last_chunk = (chunk_idx >= eff_chunks - 1'b1);

  assign in_hact   = running && active_line && ({1'b0, hcnt} >= hact_start) && !done;
  assign chunk_stb = in_hact && !seg_null && (seg_pos == '0);
  assign null_stb  = in_hact &&  seg_null && (seg_pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !running || line_last) begin
      seg_pos   <= '0;
      seg_null  <= 1'b0;
      chunk_idx <= '0;
      done      <= 1'b0;
    end else if (in_hact) begin
      if (!seg_null) begin
        if (seg_pos >= eff_pkt - 1'b1) begin
          seg_pos <= '0;
          if (eff_null != '0) seg_null <= 1'b1;
          else if (last_chunk) done <= 1'b1;
          else chunk_idx <= chunk_idx + 1'b1;
        end else begin
          seg_pos <= seg_pos + 1'b1;
        end
      end else begin
        if (seg_pos >= eff_null - 1'b1) begin
          seg_pos  <= '0;
          seg_null <= 1'b0;
          if (last_chunk) done <= 1'b1;
          else chunk_idx <= chunk_idx + 1'b1;
        end else begin
          seg_pos <= seg_pos + 1'b1;
        end
      end
    end
  end

  a_r9_burst_no_null: assert property (@(posedge clk) disable iff (!rst_n)
    null_stb |-> !burst);

  a_r10_chunk_active_line: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_stb || null_stb) |-> (running && active_line));

endmodule

// File: rtl/dsi_vseq_lpgate.sv
module dsi_vseq_lpgate
  import dsi_vseq_pkg::*;
#(
  parameter int HT_W = 16
) (
  input  logic               running,
  input  vreg_e              vreg,
  input  hreg_e              hreg,
  input  logic [HT_W-1:0]    hcnt,
  input  logic [HT_W-1:0]    hsa_time,
  input  logic               pulse_mode,
  input  logic [LP_BITS-1:0] lp_en,
  output logic               lp_ok
);

  logic grant;
  logic pending;

  always_comb begin
    grant = 1'b0;
    if (vreg != V_ACT) begin
      case (vreg)
        V_SYNC:  grant = lp_en[LP_VSYNC];
        V_BACK:  grant = lp_en[LP_VBACK];
        default: grant = lp_en[LP_VFRNT];
      endcase
    end else begin
      case (hreg)
        H_SYNC:  grant = lp_en[LP_VACT];
        H_BACK:  grant = lp_en[LP_HBACK];
        H_FRONT: grant = lp_en[LP_HFRNT];
        default: grant = 1'b0;
      endcase
    end
  end

  // a sync packet is still due: line start, or up to sync end in pulse mode
  assign pending = (hcnt == '0) || (pulse_mode && hcnt <= hsa_time);
  assign lp_ok   = running && grant && !pending && (hreg != H_ACT);

endmodule

// File: rtl/dsi_video_sequencer.sv
module dsi_video_sequencer
  import dsi_vseq_pkg::*;
#(
  parameter int HT_W  = 16,
  parameter int VL_W  = 10,
  parameter int VA_W  = 12,
  parameter int PS_W  = 16,
  parameter int CNT_W = 16,
  parameter int NS_W  = 10,
  parameter int DLY_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [1:0]            cfg_mode,
  input  logic [2*HT_W-1:0]     cfg_hblk,
  input  logic [HT_W-1:0]       cfg_line_time,
  input  logic [3*VL_W-1:0]     cfg_vblk,
  input  logic [VA_W-1:0]       cfg_vact,
  input  logic [PS_W+CNT_W-1:0] cfg_pkt,
  input  logic [NS_W-1:0]       cfg_null_size,
  input  logic [5:0]            cfg_lp_en,
  input  logic [DLY_W-1:0]      cfg_sig_delay,
  output logic [1:0]            vreg,
  output logic [1:0]            hreg,
  output logic                  sync_start,
  output logic                  sync_end,
  output logic                  chunk_stb,
  output logic                  null_stb,
  output logic                  lp_ok
);

  logic [HT_W-1:0] hsa_time;
  logic [HT_W-1:0] hbp_time;
  logic [HT_W:0]   hact_start;
  logic            pulse_mode;
  logic            burst;
  logic            running;
  logic [HT_W-1:0] hcnt;
  vreg_e           vreg_q;
  hreg_e           hreg_d;
  logic            line_last;
  logic            in_hact;

  assign hsa_time   = cfg_hblk[2*HT_W-1:HT_W];
  assign hbp_time   = cfg_hblk[HT_W-1:0];
  assign hact_start = {1'b0, hsa_time} + {1'b0, hbp_time};
  assign pulse_mode = (cfg_mode == MODE_PULSE);
  assign burst      = cfg_mode[1];

  dsi_vseq_timer #(
    .HT_W(HT_W), .VL_W(VL_W), .VA_W(VA_W), .DLY_W(DLY_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .line_time  (cfg_line_time),
    .vsa_lines  (cfg_vblk[3*VL_W-1:2*VL_W]),
    .vbp_lines  (cfg_vblk[2*VL_W-1:VL_W]),
    .vfp_lines  (cfg_vblk[VL_W-1:0]),
    .vact_lines (cfg_vact),
    .sig_delay  (cfg_sig_delay),
    .running    (running),
    .hcnt       (hcnt),
    .vreg       (vreg_q),
    .line_last  (line_last)
  );

  dsi_vseq_chunker #(
    .HT_W(HT_W), .PS_W(PS_W), .CNT_W(CNT_W), .NS_W(NS_W)
  ) u_chunker (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (running),
    .active_line (vreg_q == V_ACT),
    .line_last   (line_last),
    .hcnt        (hcnt),
    .hact_start  (hact_start),
    .pkt_size    (cfg_pkt[PS_W-1:0]),
    .chunks      (cfg_pkt[PS_W+CNT_W-1:PS_W]),
    .null_size   (cfg_null_size),
    .burst       (burst),
    .in_hact     (in_hact),
    .chunk_stb   (chunk_stb),
    .null_stb    (null_stb)
  );

  always_comb begin
    if (!running)                          hreg_d = H_SYNC;
    else if (hcnt < hsa_time)              hreg_d = H_SYNC;
    else if ({1'b0, hcnt} < hact_start)    hreg_d = H_BACK;
    else if (in_hact)                      hreg_d = H_ACT;
    else                                   hreg_d = H_FRONT;
  end

  dsi_vseq_lpgate #(.HT_W(HT_W)) u_lpgate (
    .running    (running),
    .vreg       (vreg_q),
    .hreg       (hreg_d),
    .hcnt       (hcnt),
    .hsa_time   (hsa_time),
    .pulse_mode (pulse_mode),
    .lp_en      (cfg_lp_en),
    .lp_ok      (lp_ok)
  );

  assign vreg       = running ? vreg_q : 2'd0;
  assign hreg       = hreg_d;
  assign sync_start = running && (hcnt == '0);
  assign sync_end   = running && pulse_mode && (hcnt == hsa_time);

  a_r12_lp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ok |-> !(sync_start || sync_end || chunk_stb || null_stb));

  a_r6_end_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_end && $past(running) && $past(running && hcnt != '0) && hsa_time != '0)
      |-> ($past(hreg) == 2'(H_SYNC)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !(sync_start || sync_end || chunk_stb || null_stb || lp_ok));

endmodule

// File: tb/tb_dsi_video_sequencer.sv
`timescale 1ns/1ps
module tb_dsi_video_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [31:0] cfg_hblk = '0;
  logic [15:0] cfg_line_time = '0;
  logic [29:0] cfg_vblk = '0;
  logic [11:0] cfg_vact = '0;
  logic [31:0] cfg_pkt = '0;
  logic [9:0]  cfg_null_size = '0;
  logic [5:0]  cfg_lp_en = '0;
  logic [23:0] cfg_sig_delay = '0;
  logic [1:0]  vreg, hreg;
  logic        sync_start, sync_end, chunk_stb, null_stb, lp_ok;

  always #2.5 clk = ~clk;

  dsi_video_sequencer dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_mode(cfg_mode), .cfg_hblk(cfg_hblk),
    .cfg_line_time(cfg_line_time), .cfg_vblk(cfg_vblk), .cfg_vact(cfg_vact),
    .cfg_pkt(cfg_pkt), .cfg_null_size(cfg_null_size), .cfg_lp_en(cfg_lp_en),
    .cfg_sig_delay(cfg_sig_delay), .vreg(vreg), .hreg(hreg), .sync_start(sync_start),
    .sync_end(sync_end), .chunk_stb(chunk_stb), .null_stb(null_stb), .lp_ok(lp_ok)
  );

  typedef struct packed {
    int mode; int hsa; int hbp; int lt;
    int vsa; int vbp; int vact; int vfp;
    int pkt; int chn; int nul; int lp;
    int ss; int se; int ch; int nu; int lpc;
  } vec_t;

  localparam int NVEC = 7;
  // stimulus | expected sync_start, sync_end, chunk, null, lp cycles per frame
  localparam vec_t VECS [NVEC] = '{
    '{0, 2, 3, 30, 1, 1, 2, 1,  4, 2, 3, 63, 5, 5, 4, 4, 107},
    '{1, 2, 3, 30, 1, 1, 2, 1,  4, 2, 3, 63, 5, 0, 4, 4, 117},
    '{2, 2, 3, 30, 1, 1, 2, 1, 10, 5, 7, 63, 5, 0, 2, 0, 125},
    '{1, 2, 3, 30, 1, 1, 2, 1,  4, 3, 0,  0, 5, 0, 6, 0,   0},
    '{0, 1, 1, 20, 0, 2, 1, 0,  6, 0, 2, 18, 3, 3, 1, 1,  36},
    '{0, 2, 3, 30, 1, 1, 2, 1,  4, 2, 3, 40, 5, 5, 4, 4,  49},
    '{1, 2, 3, 30, 1, 1, 2, 1,  4, 2, 3,  4, 5, 0, 4, 4,   2}
  };

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic load(input vec_t v, input int dly);
    cfg_mode      = 2'(v.mode);
    cfg_hblk      = {16'(v.hsa), 16'(v.hbp)};
    cfg_line_time = 16'(v.lt);
    cfg_vblk      = {10'(v.vsa), 10'(v.vbp), 10'(v.vfp)};
    cfg_vact      = 12'(v.vact);
    cfg_pkt       = {16'(v.chn), 16'(v.pkt)};
    cfg_null_size = 10'(v.nul);
    cfg_lp_en     = 6'(v.lp);
    cfg_sig_delay = 24'(dly);
  endtask

  function automatic int exp_region(input vec_t v, input int ln);
    if (ln < v.vsa) return 0;
    if (ln < v.vsa + v.vbp) return 1;
    if (ln < v.vsa + v.vbp + v.vact) return 2;
    return 3;
  endfunction

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    int total, c_ss, c_se, c_ch, c_nu, c_lp;
    bit found = 0;
    load(v, 0);
    run = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    for (int w = 0; w < 100 && !found; w++) begin
      @(negedge clk);
      if (sync_start) found = 1;
    end
    chk(found, "R3 first line start", int'(found), 1);
    total = (v.vsa + v.vbp + v.vact + v.vfp) * v.lt;
    c_ss = 0; c_se = 0; c_ch = 0; c_nu = 0; c_lp = 0;
    for (int c = 0; c < total; c++) begin
      int h = c % v.lt;
      int ln = c / v.lt;
      c_ss += int'(sync_start);
      c_se += int'(sync_end);
      c_ch += int'(chunk_stb);
      c_nu += int'(null_stb);
      c_lp += int'(lp_ok);
      if (h == 0) chk(int'(vreg) == exp_region(v, ln), "R5 vertical order", int'(vreg), exp_region(v, ln));
      if (i == 0) begin
        // R4 R6 R10 R13: hsa 2, hbp 3, chunks at 5 and 12, nulls at 9 and 16
        bit act = (exp_region(v, ln) == 2);
        int eh = (h < 2) ? 0 : (h < 5) ? 1 : (act && h < 19) ? 2 : 3;
        bit ech = act && (h == 5 || h == 12);
        bit enu = act && (h == 9 || h == 16);
        chk(int'(hreg) == eh, "R4 R13 hreg map", int'(hreg), eh);
        chk(sync_end == (h == 2), "R6 sync_end place", int'(sync_end), int'(h == 2));
        chk(chunk_stb == ech, "R7 R10 chunk place", int'(chunk_stb), int'(ech));
        chk(null_stb == enu, "R7 R10 null place", int'(null_stb), int'(enu));
      end
      @(negedge clk);
    end
    run = 1'b0;
    chk(c_ss == v.ss, "R3 line starts", c_ss, v.ss);
    chk(c_se == v.se, "R6 sync ends", c_se, v.se);
    chk(c_ch == v.ch, "R7 R9 chunk count", c_ch, v.ch);
    chk(c_nu == v.nu, "R8 R9 null count", c_nu, v.nu);
    chk(c_lp == v.lpc, "R11 R12 lp cycles", c_lp, v.lpc);
  endtask

  task automatic delay_test(input int dly);
    int n = 0;
    bit seen = 0;
    load(VECS[1], dly);
    run = 1'b0;
    repeat (2) @(negedge clk);
    run = 1'b1;
    while (!seen && n < 100) begin
      @(negedge clk);
      n++;
      if (sync_start) seen = 1;
    end
    chk(n == dly + 1, "R2 start delay", n, dly + 1);
    run = 1'b0;
  endtask

  initial begin
    load(VECS[0], 0);
    repeat (3) @(negedge clk);
    chk({sync_start, sync_end, chunk_stb, null_stb, lp_ok} == 5'b0, "R1 reset strobes",
        int'({sync_start, sync_end, chunk_stb, null_stb, lp_ok}), 0);
    chk({vreg, hreg} == 4'b0, "R1 reset regions", int'({vreg, hreg}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sync_start && !lp_ok, "R1 idle with run low", int'(sync_start), 0);

    for (int i = 0; i < NVEC; i++) run_vec(i);

    delay_test(0);
    delay_test(5);

    // R1: dropping run mid-frame returns to idle in the next cycle
    load(VECS[1], 0);
    run = 1'b1;
    repeat (70) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk({sync_start, sync_end, chunk_stb, null_stb, lp_ok} == 5'b0, "R1 stop strobes",
        int'({sync_start, sync_end, chunk_stb, null_stb, lp_ok}), 0);
    chk({vreg, hreg} == 4'b0, "R1 stop regions", int'({vreg, hreg}), 0);

    finish_run();
  end

endmodule